// File: doc/BRIEF.md
# Miss Entry with Primary and Deferred Target Queues

This block is a single miss-tracking entry for a non-blocking cache. It remembers one outstanding block miss (block address, size, secure bit, order number, ready time) and the requests waiting on it. Waiting requests go into one of two FIFOs. The primary queue holds the requests that the current outgoing request will satisfy. The deferred queue holds the requests that need a second request once the response has arrived. Each new target is sorted into one queue by the entry's ownership state: in service, pending-dirty, post-invalidate, post-downgrade and forward.

The surrounding cache controller drives single-cycle command strobes, at most one per clock. The commands are allocate, add-target, mark-in-service, fill, promote, pop, deallocate, upgrade conversion and snoop flag update. The entry answers with its flags, both queue heads, the counts, and one-cycle result strobes.

Add-target is the only data input. Its back-pressure rule is that `add_stall_o` rises in the same cycle as `add_i` whenever the two queues together already hold DEPTH targets. A stalled add is dropped, and the controller must present it again later. All other pins are plain control and status.

Top module: `miss_entry`

## Requirements
- R1: After an active-low synchronous reset both queue counts are 0 and in-service, pending-dirty, post-invalidate, post-downgrade and full are all 0.
- R2: Allocate latches block address, size, secure, uncacheable, order and ready time from the first target, and clears in-service, forward, no-response and downstream-pending. The first target enters the primary queue with marked-pending 1. Its source code is 2 (prefetcher) when its command code is 7 (hardware prefetch) and 0 (CPU) otherwise.
- R3: Each queue has a needs-exclusive flag and a has-upgrade flag. Both are set only by targets whose source is not 1 (snoop). Has-upgrade is set by command codes 2 (upgrade), 3 (SC-upgrade) and 5 (store-conditional).
- R4: A non-snoop target goes to the deferred queue only if the entry is in service and one of these holds: the deferred queue is non-empty, post-invalidate is set, or the target needs exclusive while pending-dirty is clear, post-downgrade is set or forward is set. Otherwise it goes to the primary queue, with marked-pending equal to NOT in-service.
- R5: A target that is deferred while post-invalidate is set has its command rewritten before storage: 2 becomes 1 (read-exclusive), 3 becomes 4 (SC-upgrade-fail) and 5 becomes 6 (store-conditional-fail).
- R6: A conversion command on a queue (`conv_deferred_i` picks the queue) does nothing when that queue's has-upgrade flag is clear. Otherwise it applies the R5 rewrite to every stored target of that queue and clears the flag.
- R7: Mark-in-service on an entry that is not a forward-without-response sets in-service. It sets pending-dirty to primary needs-exclusive OR `pend_dirty_resp_i`, and clears post-invalidate and post-downgrade.
- R8: Mark-in-service on an entry with forward and no-response both set raises `svc_done_o`, pops the single primary target and leaves in-service clear.
- R9: Promote succeeds (`promote_ok_o`) only with an empty primary queue and a non-empty deferred queue. The deferred targets and flags then become the primary ones, the deferred flags reset, order takes the new head's order, and ready time becomes max(`now_i`, head ready time).
- R10: A fill that is not shared, with post-invalidate and post-downgrade clear and deferred needs-exclusive set, appends all deferred targets behind the primary ones in order. It sets primary needs-exclusive, empties the deferred queue, resets its flags and raises `fill_merge_o`.
- R11: An add to an entry allocated uncacheable, or an add with command 7, raises `add_illegal_o` in that cycle and stores nothing.
- R12: Both queues share DEPTH slots. `full_o` is set when the counts sum to DEPTH, and an add in that state raises `add_stall_o` and stores nothing.
- R13: Deallocate with both queues empty clears in-service, pending-dirty and all queue flags. With any target queued it has no effect.
- R14: Pop removes the primary head, and targets leave each queue in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Allocate strobe, first target on tgt_* |
| blk_addr_i | input | ADDR_W | Block address for allocate |
| blk_size_i | input | SIZE_W | Block size for allocate |
| secure_i | input | 1 | Secure attribute for allocate |
| uncache_i | input | 1 | Uncacheable attribute for allocate |
| add_i | input | 1 | Add-target strobe (valid) |
| tgt_cmd_i | input | 4 | Target command code |
| tgt_src_i | input | 2 | Target source code (0 CPU, 1 snoop, 2 prefetcher) |
| tgt_excl_i | input | 1 | Target needs an exclusive copy |
| tgt_order_i | input | ORD_W | Target order number |
| tgt_ready_i | input | TIME_W | Target ready time |
| tgt_mark_i | input | 1 | Marked-pending bit for snoop targets |
| svc_i | input | 1 | Mark-in-service strobe |
| pend_dirty_resp_i | input | 1 | Response will bring a dirty copy |
| fill_i | input | 1 | Fill strobe |
| fill_shared_i | input | 1 | Fill response is marked shared |
| promote_i | input | 1 | Promote strobe |
| now_i | input | TIME_W | Current time |
| pop_i | input | 1 | Pop primary head |
| dealloc_i | input | 1 | Deallocate strobe |
| conv_i | input | 1 | Upgrade conversion strobe |
| conv_deferred_i | input | 1 | Conversion targets deferred (1) or primary (0) queue |
| flag_upd_i | input | 1 | Snoop flag update strobe |
| set_post_inv_i | input | 1 | Set post-invalidate |
| set_post_dg_i | input | 1 | Set post-downgrade |
| set_fwd_i | input | 1 | Set forward |
| set_no_resp_i | input | 1 | Set no-response |
| set_ds_pend_i | input | 1 | Set downstream-pending |
| blk_addr_o | output | ADDR_W | Latched block address |
| blk_size_o | output | SIZE_W | Latched block size |
| secure_o | output | 1 | Latched secure bit |
| uncache_o | output | 1 | Latched uncacheable bit |
| ready_time_o | output | TIME_W | Entry ready time |
| order_o | output | ORD_W | Entry order number |
| in_service_o | output | 1 | Request issued |
| pend_dirty_o | output | 1 | Ownership pending |
| post_inv_o | output | 1 | Post-invalidate flag |
| post_dg_o | output | 1 | Post-downgrade flag |
| forward_o | output | 1 | Forward flag |
| no_resp_o | output | 1 | No-response flag |
| ds_pend_o | output | 1 | Downstream-pending flag |
| p_excl_o | output | 1 | Primary needs-exclusive |
| p_upg_o | output | 1 | Primary has-upgrade |
| d_excl_o | output | 1 | Deferred needs-exclusive |
| d_upg_o | output | 1 | Deferred has-upgrade |
| p_cnt_o | output | CNT_W | Primary count |
| d_cnt_o | output | CNT_W | Deferred count |
| full_o | output | 1 | Shared capacity exhausted |
| add_stall_o | output | 1 | Add refused for capacity |
| add_illegal_o | output | 1 | Add refused as illegal |
| svc_done_o | output | 1 | Forward-without-response completed |
| promote_ok_o | output | 1 | Promote performed |
| fill_merge_o | output | 1 | Fill merged deferred targets |
| p_head_cmd_o | output | 4 | Primary head command |
| p_head_src_o | output | 2 | Primary head source |
| p_head_order_o | output | ORD_W | Primary head order |
| p_head_ready_o | output | TIME_W | Primary head ready time |
| p_head_mark_o | output | 1 | Primary head marked-pending |
| d_head_cmd_o | output | 4 | Deferred head command |
| d_head_mark_o | output | 1 | Deferred head marked-pending |

## Verification
Placement is tried with targets that differ in one ownership condition at a time. These are: before and after service, pending-dirty set or clear, post-downgrade, post-invalidate, and a deferred queue already occupied. The tests show which clause sends a target aside. Upgrade rewriting is driven both by deferral under post-invalidate and by the explicit command, with the has-upgrade flag set and clear, so that a gated no-op is told apart from an unconditional rewrite. Promote and fill are each tried once where they must refuse and once where they act, and the promote cases cover both branches of the ready-time maximum. Capacity is filled with targets spread across both queues, to show that the limit is shared.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
  localparam int ORD_W  = 16;
  localparam int TIME_W = 32;

  localparam logic [3:0] CMD_READ     = 4'd0;
  localparam logic [3:0] CMD_READEX   = 4'd1;
  localparam logic [3:0] CMD_UPG      = 4'd2;
  localparam logic [3:0] CMD_SCUPG    = 4'd3;
  localparam logic [3:0] CMD_SCUPG_F  = 4'd4;
  localparam logic [3:0] CMD_SC       = 4'd5;
  localparam logic [3:0] CMD_SC_F     = 4'd6;
  localparam logic [3:0] CMD_HWPF     = 4'd7;

  localparam logic [1:0] SRC_CPU   = 2'd0;
  localparam logic [1:0] SRC_SNOOP = 2'd1;
  localparam logic [1:0] SRC_PF    = 2'd2;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [1:0]        src;
    logic [ORD_W-1:0]  ord;
    logic [TIME_W-1:0] rdy;
    logic              mark;
  } tgt_rec_t;

  function automatic logic [3:0] fail_cmd(input logic [3:0] c);
    case (c)
      CMD_UPG:   return CMD_READEX;
      CMD_SCUPG: return CMD_SCUPG_F;
      CMD_SC:    return CMD_SC_F;
      default:   return c;
    endcase
  endfunction

  function automatic logic is_upg(input logic [3:0] c);
    return (c == CMD_UPG) || (c == CMD_SCUPG) || (c == CMD_SC);
  endfunction
endpackage

// File: rtl/miss_tgt_queue.sv
module miss_tgt_queue
  import miss_entry_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  push_i,
  input  tgt_rec_t              push_rec_i,
  input  logic                  pop_i,
  input  logic                  load_i,
  input  logic [CW-1:0]         load_cnt_i,
  input  tgt_rec_t [DEPTH-1:0]  load_vec_i,
  input  logic                  conv_i,
  output logic [CW-1:0]         cnt_o,
  output tgt_rec_t [DEPTH-1:0]  vec_o
);
  tgt_rec_t [DEPTH-1:0] slot_q;
  logic [CW-1:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      if (int'(cnt_q) < DEPTH) begin
        for (int i = 0; i < DEPTH; i++)
          if (i == int'(cnt_q)) slot_q[i] <= push_rec_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop_i) begin
      if (cnt_q != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (load_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (i >= int'(cnt_q) && i < int'(cnt_q) + int'(load_cnt_i))
          slot_q[i] <= load_vec_i[i - int'(cnt_q)];
      cnt_q <= cnt_q + load_cnt_i;
    end else if (conv_i) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i].cmd <= fail_cmd(slot_q[i].cmd);
    end
  end

  assign cnt_o = cnt_q;
  assign vec_o = slot_q;
endmodule

// File: rtl/miss_entry.sv
module miss_entry
  import miss_entry_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] blk_addr_i,
  input  logic [SIZE_W-1:0] blk_size_i,
  input  logic              secure_i,
  input  logic              uncache_i,
  input  logic              add_i,
  input  logic [3:0]        tgt_cmd_i,
  input  logic [1:0]        tgt_src_i,
  input  logic              tgt_excl_i,
  input  logic [ORD_W-1:0]  tgt_order_i,
  input  logic [TIME_W-1:0] tgt_ready_i,
  input  logic              tgt_mark_i,
  input  logic              svc_i,
  input  logic              pend_dirty_resp_i,
  input  logic              fill_i,
  input  logic              fill_shared_i,
  input  logic              promote_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic              pop_i,
  input  logic              dealloc_i,
  input  logic              conv_i,
  input  logic              conv_deferred_i,
  input  logic              flag_upd_i,
  input  logic              set_post_inv_i,
  input  logic              set_post_dg_i,
  input  logic              set_fwd_i,
  input  logic              set_no_resp_i,
  input  logic              set_ds_pend_i,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [SIZE_W-1:0] blk_size_o,
  output logic              secure_o,
  output logic              uncache_o,
  output logic [TIME_W-1:0] ready_time_o,
  output logic [ORD_W-1:0]  order_o,
  output logic              in_service_o,
  output logic              pend_dirty_o,
  output logic              post_inv_o,
  output logic              post_dg_o,
  output logic              forward_o,
  output logic              no_resp_o,
  output logic              ds_pend_o,
  output logic              p_excl_o,
  output logic              p_upg_o,
  output logic              d_excl_o,
  output logic              d_upg_o,
  output logic [CNT_W-1:0]  p_cnt_o,
  output logic [CNT_W-1:0]  d_cnt_o,
  output logic              full_o,
  output logic              add_stall_o,
  output logic              add_illegal_o,
  output logic              svc_done_o,
  output logic              promote_ok_o,
  output logic              fill_merge_o,
  output logic [3:0]        p_head_cmd_o,
  output logic [1:0]        p_head_src_o,
  output logic [ORD_W-1:0]  p_head_order_o,
  output logic [TIME_W-1:0] p_head_ready_o,
  output logic              p_head_mark_o,
  output logic [3:0]        d_head_cmd_o,
  output logic              d_head_mark_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [TIME_W-1:0] rdy_q;
  logic [ORD_W-1:0]  ord_q;
  logic sec_q, unc_q, svc_q, pdirty_q, pinv_q, pdg_q, fwd_q, nr_q, dsp_q;
  logic pex_q, pup_q, dex_q, dup_q;

  logic [CNT_W-1:0]     p_cnt, d_cnt;
  tgt_rec_t [DEPTH-1:0] p_vec, d_vec;
  logic [CNT_W:0]       total;

  logic from_snoop, is_pf, illegal, full, add_go, defer;
  logic p_push, d_push, p_pop, p_load, p_conv, d_conv;
  logic fwd_nr, svc_norm, prom_ok, merge, dealloc_ok;
  tgt_rec_t rec;

  assign total      = {1'b0, p_cnt} + {1'b0, d_cnt};
  assign full       = (total == (CNT_W+1)'(DEPTH));
  assign from_snoop = (tgt_src_i == SRC_SNOOP);
  assign is_pf      = (tgt_cmd_i == CMD_HWPF);
  assign illegal    = add_i && (unc_q || is_pf);
  assign add_go     = add_i && !illegal && !full;
  assign defer      = !from_snoop && svc_q &&
                      ((d_cnt != '0) || pinv_q ||
                       (tgt_excl_i && (!pdirty_q || pdg_q || fwd_q)));

  always_comb begin
    rec.cmd = (defer && pinv_q && !alloc_i) ? fail_cmd(tgt_cmd_i) : tgt_cmd_i;
    rec.src = alloc_i ? (is_pf ? SRC_PF : SRC_CPU) : tgt_src_i;
    rec.ord = tgt_order_i;
    rec.rdy = tgt_ready_i;
    if (alloc_i)         rec.mark = 1'b1;
    else if (from_snoop) rec.mark = tgt_mark_i;
    else if (defer)      rec.mark = 1'b1;
    else                 rec.mark = !svc_q;
  end

  assign p_push     = alloc_i || (add_go && !defer);
  assign d_push     = add_go && defer;
  assign fwd_nr     = fwd_q && nr_q;
  assign svc_norm   = svc_i && !fwd_nr;
  assign prom_ok    = promote_i && (p_cnt == '0) && (d_cnt != '0);
  assign merge      = fill_i && !fill_shared_i && !pinv_q && !pdg_q && dex_q;
  assign p_pop      = (pop_i && (p_cnt != '0)) || (svc_i && fwd_nr);
  assign p_load     = prom_ok || merge;
  assign p_conv     = conv_i && !conv_deferred_i && pup_q;
  assign d_conv     = conv_i && conv_deferred_i && dup_q;
  assign dealloc_ok = dealloc_i && (p_cnt == '0) && (d_cnt == '0);

  miss_tgt_queue #(.DEPTH(DEPTH)) u_prim (
    .clk(clk), .rst_n(rst_n), .clear_i(1'b0),
    .push_i(p_push), .push_rec_i(rec), .pop_i(p_pop),
    .load_i(p_load), .load_cnt_i(d_cnt), .load_vec_i(d_vec),
    .conv_i(p_conv), .cnt_o(p_cnt), .vec_o(p_vec)
  );

  miss_tgt_queue #(.DEPTH(DEPTH)) u_defr (
    .clk(clk), .rst_n(rst_n), .clear_i(p_load),
    .push_i(d_push), .push_rec_i(rec), .pop_i(1'b0),
    .load_i(1'b0), .load_cnt_i('0), .load_vec_i('0),
    .conv_i(d_conv), .cnt_o(d_cnt), .vec_o(d_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; size_q <= '0; rdy_q <= '0; ord_q <= '0;
      sec_q <= 1'b0; unc_q <= 1'b0; svc_q <= 1'b0; pdirty_q <= 1'b0;
      pinv_q <= 1'b0; pdg_q <= 1'b0; fwd_q <= 1'b0; nr_q <= 1'b0; dsp_q <= 1'b0;
      pex_q <= 1'b0; pup_q <= 1'b0; dex_q <= 1'b0; dup_q <= 1'b0;
    end else if (alloc_i) begin
      addr_q <= blk_addr_i; size_q <= blk_size_i; sec_q <= secure_i;
      unc_q  <= uncache_i;  rdy_q  <= tgt_ready_i; ord_q <= tgt_order_i;
      svc_q <= 1'b0; fwd_q <= 1'b0; nr_q <= 1'b0; dsp_q <= 1'b0;
      pex_q <= tgt_excl_i; pup_q <= is_upg(tgt_cmd_i);
      dex_q <= 1'b0; dup_q <= 1'b0;
    end else if (add_go) begin
      if (!from_snoop) begin
        if (defer) begin
          dex_q <= dex_q | tgt_excl_i;
          dup_q <= dup_q | is_upg(rec.cmd);
        end else begin
          pex_q <= pex_q | tgt_excl_i;
          pup_q <= pup_q | is_upg(rec.cmd);
        end
      end
    end else if (svc_norm) begin
      svc_q    <= 1'b1;
      pdirty_q <= pex_q | pend_dirty_resp_i;
      pinv_q   <= 1'b0;
      pdg_q    <= 1'b0;
    end else if (prom_ok) begin
      pex_q <= dex_q; pup_q <= dup_q; dex_q <= 1'b0; dup_q <= 1'b0;
      ord_q <= d_vec[0].ord;
      rdy_q <= (now_i > d_vec[0].rdy) ? now_i : d_vec[0].rdy;
    end else if (merge) begin
      pex_q <= 1'b1; dex_q <= 1'b0; dup_q <= 1'b0;
    end else if (p_conv) begin
      pup_q <= 1'b0;
    end else if (d_conv) begin
      dup_q <= 1'b0;
    end else if (dealloc_ok) begin
      svc_q <= 1'b0; pdirty_q <= 1'b0; pinv_q <= 1'b0; pdg_q <= 1'b0;
      pex_q <= 1'b0; pup_q <= 1'b0; dex_q <= 1'b0; dup_q <= 1'b0;
    end else if (flag_upd_i) begin
      pinv_q <= pinv_q | set_post_inv_i;
      pdg_q  <= pdg_q  | set_post_dg_i;
      fwd_q  <= fwd_q  | set_fwd_i;
      nr_q   <= nr_q   | set_no_resp_i;
      dsp_q  <= dsp_q  | set_ds_pend_i;
    end
  end

  assign blk_addr_o     = addr_q;
  assign blk_size_o     = size_q;
  assign secure_o       = sec_q;
  assign uncache_o      = unc_q;
  assign ready_time_o   = rdy_q;
  assign order_o        = ord_q;
  assign in_service_o   = svc_q;
  assign pend_dirty_o   = pdirty_q;
  assign post_inv_o     = pinv_q;
  assign post_dg_o      = pdg_q;
  assign forward_o      = fwd_q;
  assign no_resp_o      = nr_q;
  assign ds_pend_o      = dsp_q;
  assign p_excl_o       = pex_q;
  assign p_upg_o        = pup_q;
  assign d_excl_o       = dex_q;
  assign d_upg_o        = dup_q;
  assign p_cnt_o        = p_cnt;
  assign d_cnt_o        = d_cnt;
  assign full_o         = full;
  assign add_stall_o    = add_i && full;
  assign add_illegal_o  = illegal;
  assign svc_done_o     = svc_i && fwd_nr;
  assign promote_ok_o   = prom_ok;
  assign fill_merge_o   = merge;
  assign p_head_cmd_o   = p_vec[0].cmd;
  assign p_head_src_o   = p_vec[0].src;
  assign p_head_order_o = p_vec[0].ord;
  assign p_head_ready_o = p_vec[0].rdy;
  assign p_head_mark_o  = p_vec[0].mark;
  assign d_head_cmd_o   = d_vec[0].cmd;
  assign d_head_mark_o  = d_vec[0].mark;
endmodule

// File: rtl/miss_entry_chk.sv
module miss_entry_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             add_i,
  input logic             svc_i,
  input logic             promote_i,
  input logic             dealloc_i,
  input logic             conv_i,
  input logic             conv_deferred_i,
  input logic             add_stall_o,
  input logic             add_illegal_o,
  input logic             svc_done_o,
  input logic             promote_ok_o,
  input logic             in_service_o,
  input logic             post_inv_o,
  input logic             post_dg_o,
  input logic             p_excl_o,
  input logic             p_upg_o,
  input logic [CNT_W-1:0] p_cnt_o,
  input logic [CNT_W-1:0] d_cnt_o
);
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(p_cnt_o) + int'(d_cnt_o)) <= DEPTH);

  p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    add_i && add_stall_o |=> $stable(p_cnt_o) && $stable(d_cnt_o));

  p_illegal_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    add_i && add_illegal_o |=> $stable(p_cnt_o) && $stable(d_cnt_o));

  p_service_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i && !svc_done_o |=> in_service_o && !post_inv_o && !post_dg_o);

  p_fwd_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i && svc_done_o && (p_cnt_o == CNT_W'(1)) |=> (p_cnt_o == '0));

  p_promote_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    promote_i && promote_ok_o |=> (d_cnt_o == '0) && (p_cnt_o == $past(d_cnt_o)));

  p_conv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_i && !conv_deferred_i |=> !p_upg_o);

  p_dealloc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc_i && (p_cnt_o == '0) && (d_cnt_o == '0) |=> !in_service_o && !p_excl_o);
endmodule

bind miss_entry miss_entry_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_i(add_i), .svc_i(svc_i),
  .promote_i(promote_i), .dealloc_i(dealloc_i), .conv_i(conv_i),
  .conv_deferred_i(conv_deferred_i), .add_stall_o(add_stall_o),
  .add_illegal_o(add_illegal_o), .svc_done_o(svc_done_o),
  .promote_ok_o(promote_ok_o), .in_service_o(in_service_o),
  .post_inv_o(post_inv_o), .post_dg_o(post_dg_o), .p_excl_o(p_excl_o),
  .p_upg_o(p_upg_o), .p_cnt_o(p_cnt_o), .d_cnt_o(d_cnt_o)
);

// File: tb/miss_entry_tb_top.sv
`timescale 1ns/1ps
module miss_entry_tb_top;
  import miss_entry_pkg::*;

  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_i, secure_i, uncache_i, add_i, tgt_excl_i, tgt_mark_i;
  logic [31:0] blk_addr_i;
  logic [7:0]  blk_size_i;
  logic [3:0]  tgt_cmd_i;
  logic [1:0]  tgt_src_i;
  logic [ORD_W-1:0]  tgt_order_i;
  logic [TIME_W-1:0] tgt_ready_i, now_i;
  logic svc_i, pend_dirty_resp_i, fill_i, fill_shared_i, promote_i, pop_i, dealloc_i;
  logic conv_i, conv_deferred_i, flag_upd_i;
  logic set_post_inv_i, set_post_dg_i, set_fwd_i, set_no_resp_i, set_ds_pend_i;

  logic [31:0] blk_addr_o;
  logic [7:0]  blk_size_o;
  logic secure_o, uncache_o, in_service_o, pend_dirty_o, post_inv_o, post_dg_o;
  logic forward_o, no_resp_o, ds_pend_o, p_excl_o, p_upg_o, d_excl_o, d_upg_o;
  logic [TIME_W-1:0] ready_time_o, p_head_ready_o;
  logic [ORD_W-1:0]  order_o, p_head_order_o;
  logic [CNT_W-1:0]  p_cnt_o, d_cnt_o;
  logic full_o, add_stall_o, add_illegal_o, svc_done_o, promote_ok_o, fill_merge_o;
  logic [3:0] p_head_cmd_o, d_head_cmd_o;
  logic [1:0] p_head_src_o;
  logic p_head_mark_o, d_head_mark_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic seen_stall, seen_illegal, seen_done, seen_prom, seen_merge;

  always #2 clk = ~clk;

  miss_entry #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    alloc_i = 0; add_i = 0; svc_i = 0; fill_i = 0; promote_i = 0; pop_i = 0;
    dealloc_i = 0; conv_i = 0; flag_upd_i = 0; pend_dirty_resp_i = 0;
    fill_shared_i = 0; conv_deferred_i = 0; set_post_inv_i = 0; set_post_dg_i = 0;
    set_fwd_i = 0; set_no_resp_i = 0; set_ds_pend_i = 0; tgt_mark_i = 0;
  endtask

  task automatic step();
    #1;
    seen_stall = add_stall_o; seen_illegal = add_illegal_o; seen_done = svc_done_o;
    seen_prom = promote_ok_o; seen_merge = fill_merge_o;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle(); alloc_i = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_tgt(input logic [3:0] c, input logic [1:0] s, input logic x,
                         input int o, input int r);
    tgt_cmd_i = c; tgt_src_i = s; tgt_excl_i = x;
    tgt_order_i = ORD_W'(o); tgt_ready_i = TIME_W'(r);
  endtask

  task automatic do_alloc(input logic [3:0] c, input logic x, input int o, input int r,
                          input logic unc);
    set_tgt(c, SRC_CPU, x, o, r);
    blk_addr_i = 32'h1234; blk_size_i = 8'd64; secure_i = 1'b1; uncache_i = unc;
    alloc_i = 1; step();
  endtask

  task automatic do_add(input logic [3:0] c, input logic [1:0] s, input logic x,
                        input int o, input int r);
    set_tgt(c, s, x, o, r); add_i = 1; step();
  endtask

  task automatic do_svc(input logic pdr);
    svc_i = 1; pend_dirty_resp_i = pdr; step();
  endtask

  task automatic do_flag(input logic pi, input logic pd, input logic fw, input logic nr);
    flag_upd_i = 1; set_post_inv_i = pi; set_post_dg_i = pd;
    set_fwd_i = fw; set_no_resp_i = nr; set_ds_pend_i = 1; step();
  endtask

  task automatic do_pop();     pop_i = 1; step(); endtask
  task automatic do_promote(input int t); promote_i = 1; now_i = TIME_W'(t); step(); endtask
  task automatic do_fill(input logic sh); fill_i = 1; fill_shared_i = sh; step(); endtask
  task automatic do_conv(input logic dsel); conv_i = 1; conv_deferred_i = dsel; step(); endtask
  task automatic do_dealloc(); dealloc_i = 1; step(); endtask

  task automatic t_reset();
    do_reset();
    chk("R1 p_cnt", p_cnt_o, 0);
    chk("R1 d_cnt", d_cnt_o, 0);
    chk("R1 flags", {in_service_o, pend_dirty_o, post_inv_o, post_dg_o, full_o}, 0);
  endtask

  task automatic t_alloc();
    do_reset();
    do_alloc(CMD_HWPF, 0, 5, 100, 0);
    chk("R2 addr", blk_addr_o, 32'h1234);
    chk("R2 size", blk_size_o, 64);
    chk("R2 secure", secure_o, 1);
    chk("R2 order", order_o, 5);
    chk("R2 ready", ready_time_o, 100);
    chk("R2 src prefetch", p_head_src_o, 2);
    chk("R2 mark", p_head_mark_o, 1);
    do_pop();
    chk("R14 pop empties", p_cnt_o, 0);
    do_flag(0, 0, 1, 1);
    chk("R2 fwd set before", forward_o, 1);
    do_alloc(CMD_READ, 0, 6, 7, 0);
    chk("R2 fwd cleared", forward_o, 0);
    chk("R2 ds_pend cleared", ds_pend_o, 0);
    chk("R2 src cpu", p_head_src_o, 0);
  endtask

  task automatic t_flags();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    tgt_mark_i = 0;
    do_add(CMD_UPG, SRC_SNOOP, 1, 2, 0);
    chk("R3 snoop no excl", p_excl_o, 0);
    chk("R3 snoop no upg", p_upg_o, 0);
    do_add(CMD_UPG, SRC_CPU, 1, 3, 0);
    chk("R3 cpu upg", p_upg_o, 1);
    chk("R3 cpu excl", p_excl_o, 1);
    chk("R4 primary count", p_cnt_o, 3);
    do_pop();
    chk("R14 order second", p_head_order_o, 2);
    chk("R14 snoop src", p_head_src_o, 1);
    chk("R4 snoop mark", p_head_mark_o, 0);
    do_pop();
    chk("R14 order third", p_head_order_o, 3);
    chk("R4 mark not in service", p_head_mark_o, 1);
  endtask

  task automatic t_place();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(0);
    chk("R7 in service", in_service_o, 1);
    chk("R7 pend dirty clear", pend_dirty_o, 0);
    do_add(CMD_READ, SRC_CPU, 0, 2, 0);
    chk("R4 shared add primary", p_cnt_o, 2);
    do_add(CMD_READEX, SRC_CPU, 1, 3, 0);
    chk("R4 excl no dirty defers", d_cnt_o, 1);
    chk("R3 deferred excl", d_excl_o, 1);
    chk("R4 deferred mark", d_head_mark_o, 1);
    do_add(CMD_READ, SRC_CPU, 0, 4, 0);
    chk("R4 deferred nonempty", d_cnt_o, 2);
    do_reset();
    do_alloc(CMD_READEX, 1, 1, 0, 0);
    do_flag(1, 1, 0, 0);
    do_svc(0);
    chk("R7 post inv cleared", post_inv_o, 0);
    chk("R7 post dg cleared", post_dg_o, 0);
    chk("R7 pend dirty from excl", pend_dirty_o, 1);
    do_add(CMD_READEX, SRC_CPU, 1, 2, 0);
    chk("R4 excl with dirty primary", p_cnt_o, 2);
    do_flag(0, 1, 0, 0);
    do_add(CMD_READEX, SRC_CPU, 1, 3, 0);
    chk("R4 post dg defers", d_cnt_o, 1);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(1);
    chk("R7 pend dirty from resp", pend_dirty_o, 1);
  endtask

  task automatic t_postinv();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(1);
    do_flag(1, 0, 0, 0);
    do_add(CMD_UPG, SRC_CPU, 1, 2, 0);
    chk("R5 deferred", d_cnt_o, 1);
    chk("R5 upgrade to readex", d_head_cmd_o, CMD_READEX);
    chk("R5 upg flag not set", d_upg_o, 0);
  endtask

  task automatic t_conv();
    do_reset();
    do_alloc(CMD_UPG, 1, 1, 0, 0);
    do_add(CMD_SC, SRC_CPU, 1, 2, 0);
    do_conv(1);
    chk("R6 other queue untouched", p_head_cmd_o, CMD_UPG);
    chk("R6 flag kept", p_upg_o, 1);
    do_conv(0);
    chk("R6 flag cleared", p_upg_o, 0);
    chk("R6 head rewritten", p_head_cmd_o, CMD_READEX);
    do_pop();
    chk("R6 sc rewritten", p_head_cmd_o, CMD_SC_F);
    do_add(CMD_UPG, SRC_SNOOP, 0, 3, 0);
    do_conv(0);
    do_pop();
    chk("R6 gated no-op", p_head_cmd_o, CMD_UPG);
  endtask

  task automatic t_fwd();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_flag(0, 0, 1, 1);
    do_svc(0);
    chk("R8 done strobe", seen_done, 1);
    chk("R8 popped", p_cnt_o, 0);
    chk("R8 not in service", in_service_o, 0);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_flag(0, 0, 1, 0);
    do_svc(0);
    chk("R8 forward with resp", seen_done, 0);
    chk("R7 forward with resp svc", in_service_o, 1);
  endtask

  task automatic t_promote();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 10, 0);
    do_svc(0);
    do_add(CMD_READEX, SRC_CPU, 1, 7, 50);
    do_promote(20);
    chk("R9 refused primary busy", seen_prom, 0);
    chk("R9 deferred kept", d_cnt_o, 1);
    do_pop();
    do_promote(20);
    chk("R9 ok", seen_prom, 1);
    chk("R9 p_cnt", p_cnt_o, 1);
    chk("R9 d_cnt", d_cnt_o, 0);
    chk("R9 order", order_o, 7);
    chk("R9 ready head", ready_time_o, 50);
    chk("R9 excl moved", {p_excl_o, d_excl_o}, 2);
    chk("R9 head cmd", p_head_cmd_o, CMD_READEX);
    do_pop();
    do_promote(9);
    chk("R9 refused empty", seen_prom, 0);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 10, 0);
    do_svc(0);
    do_add(CMD_READEX, SRC_CPU, 1, 8, 30);
    do_pop();
    do_promote(90);
    chk("R9 ready now", ready_time_o, 90);
    chk("R9 order2", order_o, 8);
  endtask

  task automatic t_fill();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(0);
    do_add(CMD_READEX, SRC_CPU, 1, 2, 0);
    do_add(CMD_READ, SRC_CPU, 0, 3, 0);
    do_fill(1);
    chk("R10 shared no merge", seen_merge, 0);
    chk("R10 shared d_cnt", d_cnt_o, 2);
    do_fill(0);
    chk("R10 merge", seen_merge, 1);
    chk("R10 p_cnt", p_cnt_o, 3);
    chk("R10 d_cnt", d_cnt_o, 0);
    chk("R10 flags", {p_excl_o, d_excl_o}, 2);
    do_pop();
    chk("R10 tail order a", p_head_order_o, 2);
    do_pop();
    chk("R10 tail order b", p_head_order_o, 3);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(0);
    do_add(CMD_READEX, SRC_CPU, 1, 2, 0);
    do_flag(0, 1, 0, 0);
    do_fill(0);
    chk("R10 post dg blocks", seen_merge, 0);
    chk("R10 post dg d_cnt", d_cnt_o, 1);
  endtask

  task automatic t_illegal();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 1);
    do_add(CMD_READ, SRC_CPU, 0, 2, 0);
    chk("R11 uncacheable flag", seen_illegal, 1);
    chk("R11 uncacheable count", p_cnt_o, 1);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_add(CMD_HWPF, SRC_CPU, 0, 2, 0);
    chk("R11 prefetch flag", seen_illegal, 1);
    chk("R11 prefetch count", p_cnt_o, 1);
    do_add(CMD_READ, SRC_CPU, 0, 3, 0);
    chk("R11 legal add", {seen_illegal, 4'(p_cnt_o)}, 2);
  endtask

  task automatic t_capacity();
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) do_add(CMD_READ, SRC_CPU, 0, 2 + i, 0);
    chk("R12 full", full_o, 1);
    do_add(CMD_READ, SRC_CPU, 0, 20, 0);
    chk("R12 stall", seen_stall, 1);
    chk("R12 count held", p_cnt_o, DEPTH);
    do_reset();
    do_alloc(CMD_READ, 0, 1, 0, 0);
    do_svc(0);
    for (int i = 0; i < 3; i++) do_add(CMD_READ, SRC_CPU, 0, 2 + i, 0);
    for (int i = 0; i < 4; i++) do_add(CMD_READEX, SRC_CPU, 1, 5 + i, 0);
    chk("R12 split counts", {4'(p_cnt_o), 4'(d_cnt_o)}, 8'h44);
    chk("R12 shared full", full_o, 1);
    do_add(CMD_READ, SRC_CPU, 0, 30, 0);
    chk("R12 shared stall", seen_stall, 1);
  endtask

  task automatic t_dealloc();
    do_reset();
    do_alloc(CMD_READEX, 1, 1, 0, 0);
    do_svc(0);
    do_dealloc();
    chk("R13 ignored busy", in_service_o, 1);
    do_pop();
    do_dealloc();
    chk("R13 in service cleared", in_service_o, 0);
    chk("R13 flags cleared", {pend_dirty_o, p_excl_o}, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    blk_addr_i = '0; blk_size_i = '0; secure_i = 0; uncache_i = 0;
    tgt_cmd_i = '0; tgt_src_i = '0; tgt_excl_i = 0; tgt_order_i = '0;
    tgt_ready_i = '0; now_i = '0;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_flags();
    t_place();
    t_postinv();
    t_conv();
    t_fwd();
    t_promote();
    t_fill();
    t_illegal();
    t_capacity();
    t_dealloc();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule